// File: doc/BRIEF.md
# Rhythm-Gated PWM Channel

A single pulse-width modulation channel with a 12-bit programmable period and high time. A slow sequencer gates it and divides time into twenty equal slots. Each slot is a fixed number of clocks set by a reload value, for example 50 ms per slot, which makes a one-second on/off pattern. A 20-bit pattern word selects which slots let the PWM waveform reach the pin. The fast period counter and the slow slot sequencer share one clock.

Software drives the block through a simple word-wide register port. Writes take effect on the next rising clock edge, and reads return data combinationally. Software programs period, duty and pattern, then starts the channel. It can raise an interrupt once per completed pattern pass and invert the output polarity. A status word reports which engines are idle.

Two state machines do the work:
- The cycle counter has the states CYC_IDLE and CYC_RUN. It takes the transition *start* (IDLE to RUN, when run is set), *wrap* (RUN to RUN, at the end of a period while run is still set) and *finish* (RUN to IDLE, at the end of a period after run is cleared).
- The slot sequencer has the states RHY_IDLE and RHY_RUN. It takes the transition *arm* (IDLE to RUN, when the rhythm enable is set), *advance* (RUN to RUN, at the end of each slot, wrapping from slot 19 to slot 0) and *disarm* (RUN to IDLE, at once when the enable is cleared).

Top module: `rhythm_pwm`

## Requirements
- R1: After reset, pwm_out and irq are 0, the status word reads 0x6 (both engines idle, nothing pending), the control word reads 0x8 (interrupt masked), and the pattern, period, duty and reload words read 0.
- R2: Register map (word addresses): 0 control, 1 pattern, 2 period, 3 duty, 4 reload, 5 status (read only), 6 interrupt clear (write only, reads 0). While running with rhythm disabled and polarity normal, each period lasts period+1 clocks, and pwm_out is high for the first duty clocks of it.
- R3: A duty greater than the period value gives a constant high output. A duty of 0 gives a constant low output.
- R4: The control word bits are: bit0 run, bit1 rhythm enable, bit2 polarity invert, bit3 interrupt mask (1 = irq suppressed).
- R5: Clearing run lets the current period finish. After that, the cycle counter goes idle (status bit1 = 1) and pwm_out holds the inactive level, which is 0 with normal polarity and 1 when inverted.
- R6: With rhythm enabled, each slot lasts reload+1 clocks. Slot 0 comes first after enabling, and the slots step 0..19 and then repeat. Pattern bit i = 1 passes the PWM waveform during slot i; bit i = 0 forces the inactive level.
- R7: With rhythm disabled, the pattern word has no effect on pwm_out.
- R8: Polarity inversion is applied after rhythm gating, so pwm_out reads 1 during masked slots when invert is set.
- R9: The pending flag (status bit0) sets when slot 19 ends. irq = pending AND NOT mask.
- R10: Writing 1 to bit0 of the interrupt-clear word clears pending, and writing 0 has no effect. If a pass ends in the same cycle as a clear, the set wins.
- R11: A write to the reload word is ignored unless rhythm enable is 0 and both idle flags read 1.
- R12: Status bit2 reads 0 while the slot sequencer runs and 1 when it is idle. Status bit1 reads 0 while the cycle counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| pwm_out | output | 1 | Gated, polarity-adjusted PWM output |
| irq | output | 1 | Level interrupt, pending and not masked |

## Verification
The hardest situation to reach from the ports is the alignment between the slot sequencer and the gated waveform: which slot is active at a given clock, and exactly when the pass-end flag sets. Using a one-clock period with duty above it makes the PWM a constant high, so pwm_out shows the gate directly. A short reload of 3 turns one pass into 80 clocks. Counting high samples over whole 80-clock windows checks the random patterns without depending on phase. A directed case samples each clock right after enabling and checks the slot order. Pending, mask and clear are then exercised with the sequencer disabled, so that no pass can end between a write and the check that follows it.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;

    typedef enum logic [2:0] {
        A_CTRL    = 3'd0,
        A_PATTERN = 3'd1,
        A_PERIOD  = 3'd2,
        A_DUTY    = 3'd3,
        A_RELOAD  = 3'd4,
        A_STATUS  = 3'd5,
        A_INTCLR  = 3'd6
    } reg_addr_e;

    typedef enum logic {
        CYC_IDLE = 1'b0,
        CYC_RUN  = 1'b1
    } cyc_state_e;

    typedef enum logic {
        RHY_IDLE = 1'b0,
        RHY_RUN  = 1'b1
    } rhy_state_e;

    // bit3 irq_mask, bit2 invert, bit1 rhy_en, bit0 run
    typedef struct packed {
        logic irq_mask;
        logic invert;
        logic rhy_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/rpwm_cycle.sv
module rpwm_cycle
    import rpwm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm_raw,
    output logic             idle
);

    cyc_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CYC_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            CYC_IDLE: begin
                cnt_n = '0;
                if (run) state_n = CYC_RUN;          // start
            end
            CYC_RUN: begin
                if (cnt == period) begin
                    cnt_n   = '0;
                    state_n = run ? CYC_RUN : CYC_IDLE; // wrap / finish
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        pwm_raw = (state == CYC_RUN) && (cnt < duty);
        idle    = (state == CYC_IDLE);
    end

    // R5
    mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_RUN && cnt != period) |=> (state == CYC_RUN));

endmodule

// File: rtl/rpwm_rhythm.sv
module rpwm_rhythm
    import rpwm_pkg::*;
#(
    parameter int SLOTS    = 20,
    parameter int RELOAD_W = 20,
    localparam int SLOT_W  = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [RELOAD_W-1:0] reload,
    output logic [SLOT_W-1:0]   slot,
    output logic                running,
    output logic                pass_done
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    rhy_state_e          state, state_n;
    logic [RELOAD_W-1:0] tick, tick_n;
    logic [SLOT_W-1:0]   slot_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RHY_IDLE;
            tick  <= '0;
            slot  <= '0;
        end else begin
            state <= state_n;
            tick  <= tick_n;
            slot  <= slot_n;
        end
    end

    always_comb begin
        state_n   = state;
        tick_n    = tick;
        slot_n    = slot;
        pass_done = 1'b0;
        unique case (state)
            RHY_IDLE: begin
                tick_n = '0;
                slot_n = '0;
                if (en) state_n = RHY_RUN;           // arm
            end
            RHY_RUN: begin
                if (!en) begin                        // disarm
                    state_n = RHY_IDLE;
                    tick_n  = '0;
                    slot_n  = '0;
                end else if (tick == reload) begin    // advance
                    tick_n = '0;
                    if (slot == LAST_SLOT) begin
                        slot_n    = '0;
                        pass_done = 1'b1;
                    end else begin
                        slot_n = slot + 1'b1;
                    end
                end else begin
                    tick_n = tick + 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        running = (state == RHY_RUN);
    end

    // R6
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, slot} < (SLOT_W + 1)'(SLOTS));

    // R6
    pass_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> (slot == '0));

endmodule

// File: rtl/rpwm_regs.sv
module rpwm_regs
    import rpwm_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int CNT_W    = 12,
    parameter int SLOTS    = 20,
    parameter int RELOAD_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                pass_done,
    input  logic                cyc_idle,
    input  logic                rhy_idle,
    output ctrl_t               ctrl,
    output logic [SLOTS-1:0]    pattern,
    output logic [CNT_W-1:0]    period,
    output logic [CNT_W-1:0]    duty,
    output logic [RELOAD_W-1:0] reload,
    output logic                pending,
    output logic [DATA_W-1:0]   rd_data
);

    logic wr_ctrl, wr_pat, wr_per, wr_duty, wr_rel, clr_req, reload_ok;
    logic unused_wdata;

    assign unused_wdata = ^wr_data;
    assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign wr_pat    = wr_en && (wr_addr == A_PATTERN);
    assign wr_per    = wr_en && (wr_addr == A_PERIOD);
    assign wr_duty   = wr_en && (wr_addr == A_DUTY);
    assign wr_rel    = wr_en && (wr_addr == A_RELOAD);
    assign clr_req   = wr_en && (wr_addr == A_INTCLR) && wr_data[0];
    assign reload_ok = !ctrl.rhy_en && cyc_idle && rhy_idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= ctrl_t'(4'b1000);
            pattern <= '0;
            period  <= '0;
            duty    <= '0;
            reload  <= '0;
            pending <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl    <= ctrl_t'(wr_data[3:0]);
            if (wr_pat)  pattern <= wr_data[SLOTS-1:0];
            if (wr_per)  period  <= wr_data[CNT_W-1:0];
            if (wr_duty) duty    <= wr_data[CNT_W-1:0];
            if (wr_rel && reload_ok) reload <= wr_data[RELOAD_W-1:0];
            if (pass_done)    pending <= 1'b1;
            else if (clr_req) pending <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:    rd_data = DATA_W'(ctrl);
            A_PATTERN: rd_data = DATA_W'(pattern);
            A_PERIOD:  rd_data = DATA_W'(period);
            A_DUTY:    rd_data = DATA_W'(duty);
            A_RELOAD:  rd_data = DATA_W'(reload);
            A_STATUS:  rd_data = DATA_W'({rhy_idle, cyc_idle, pending});
            default:   rd_data = '0;
        endcase
    end

    // R11
    reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rhy_idle || !cyc_idle) |=> $stable(reload));

    // R9
    pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(pass_done));

endmodule

// File: rtl/rhythm_pwm.sv
module rhythm_pwm
    import rpwm_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int CNT_W    = 12,
    parameter int SLOTS    = 20,
    parameter int RELOAD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out,
    output logic              irq
);

    localparam int SLOT_W = $clog2(SLOTS);

    ctrl_t               ctrl;
    logic [SLOTS-1:0]    pattern;
    logic [CNT_W-1:0]    period, duty;
    logic [RELOAD_W-1:0] reload;
    logic                pending, pass_done, cyc_idle, rhy_run, pwm_raw, gate;
    logic [SLOT_W-1:0]   slot;

    rpwm_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .SLOTS(SLOTS), .RELOAD_W(RELOAD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr),
        .pass_done(pass_done), .cyc_idle(cyc_idle), .rhy_idle(!rhy_run),
        .ctrl(ctrl), .pattern(pattern), .period(period), .duty(duty),
        .reload(reload), .pending(pending), .rd_data(rd_data)
    );

    rpwm_cycle #(.CNT_W(CNT_W)) u_cycle (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run),
        .period(period), .duty(duty),
        .pwm_raw(pwm_raw), .idle(cyc_idle)
    );

    rpwm_rhythm #(.SLOTS(SLOTS), .RELOAD_W(RELOAD_W)) u_rhythm (
        .clk(clk), .rst_n(rst_n), .en(ctrl.rhy_en), .reload(reload),
        .slot(slot), .running(rhy_run), .pass_done(pass_done)
    );

    always_comb begin
        gate    = rhy_run ? pattern[slot] : 1'b1;
        pwm_out = (pwm_raw & gate) ^ ctrl.invert;
        irq     = pending & ~ctrl.irq_mask;
    end

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_idle |-> (pwm_out == ctrl.invert));

    // R8
    gate_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rhy_run && !pattern[slot]) |-> (pwm_out == ctrl.invert));

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pending && !ctrl.irq_mask));

endmodule

// File: tb/sim_rhythm_pwm.sv
`timescale 1ns/1ps
module sim_rhythm_pwm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pwm_out, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [2:0] AC = 3'd0, AP = 3'd1, APER = 3'd2, AD = 3'd3,
                           AR = 3'd4, AS = 3'd5, AI = 3'd6;

    always #2.5 clk = ~clk;

    rhythm_pwm u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .irq(irq)
    );

    function automatic int exp_pwm(int cyc, int dt, int nper);
        return nper * ((dt > cyc) ? (cyc + 1) : dt);
    endfunction

    function automatic int exp_rhy(logic [19:0] pat, int slen, bit inv);
        int pop = 0;
        for (int i = 0; i < 20; i++) pop += pat[i];
        return inv ? (20 - pop) * slen : pop * slen;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic cnt_hi(input int n, output int h);
        h = 0;
        repeat (n) begin
            @(negedge clk);
            h += int'(pwm_out);
        end
    endtask

    task automatic stop_wait(input logic [31:0] c);
        logic [31:0] s;
        wr(AC, c);
        for (int k = 0; k < 5000; k++) begin
            rd(AS, s);
            if (s[2:1] == 2'b11) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [19:0] pat;
        int h, cyc, dt, seed;
        seed = $urandom(32'h5EED_0C0D);

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R4 mask default
        chk("R1 pwm_out", 32'(pwm_out), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(AS, r); chk("R1 status", r, 32'h6);
        rd(AC, r); chk("R1 R4 ctrl", r, 32'h8);
        rd(AP, r); chk("R1 pattern", r, 0);
        rd(AR, r); chk("R1 reload", r, 0);
        rd(AI, r); chk("R2 intclr reads 0", r, 0);

        // R2 directed: period 10, duty 3
        wr(APER, 9); wr(AD, 3); wr(AC, 32'h1);
        repeat (12) @(negedge clk);
        rd(AS, r); chk("R12 cycle running", 32'(r[1]), 0);
        cnt_hi(30, h); chk("R2 cyc9 duty3", h, exp_pwm(9, 3, 3));
        // R3 boundaries
        stop_wait(0); wr(AD, 0); wr(AC, 1); repeat (12) @(negedge clk);
        cnt_hi(30, h); chk("R3 duty0", h, 0);
        stop_wait(0); wr(AD, 15); wr(AC, 1); repeat (12) @(negedge clk);
        cnt_hi(30, h); chk("R3 duty>cycle", h, 30);
        stop_wait(0); wr(AD, 10); wr(AC, 1); repeat (12) @(negedge clk);
        cnt_hi(30, h); chk("R3 duty=cycle+1", h, 30);
        stop_wait(0); wr(AD, 9); wr(AC, 1); repeat (12) @(negedge clk);
        cnt_hi(30, h); chk("R2 duty=cycle", h, exp_pwm(9, 9, 3));

        // R5 stop at period boundary
        stop_wait(0); wr(APER, 99); wr(AD, 50); wr(AC, 1);
        repeat (30) @(negedge clk);
        wr(AC, 0);
        rd(AS, r); chk("R5 still running after clear", 32'(r[1]), 0);
        repeat (110) @(negedge clk);
        rd(AS, r); chk("R5 idle after boundary", 32'(r[1]), 1);
        cnt_hi(20, h); chk("R5 inactive level", h, 0);

        // R2/R3 random
        for (int it = 0; it < 12; it++) begin
            cyc = int'($urandom % 16);
            dt  = int'($urandom % 20);
            stop_wait(0);
            wr(APER, cyc); wr(AD, dt); wr(AC, 1);
            repeat (cyc + 4) @(negedge clk);
            cnt_hi(3 * (cyc + 1), h);
            chk($sformatf("R2 R3 rand cyc=%0d duty=%0d", cyc, dt), h, exp_pwm(cyc, dt, 3));
        end

        // R11 accepted when idle
        stop_wait(0);
        wr(AR, 3); rd(AR, r); chk("R11 reload accepted idle", r, 3);
        wr(APER, 0); wr(AD, 1); wr(AP, 32'h3); wr(AC, 1);
        repeat (5) @(negedge clk);
        // R11 ignored while cycle counter runs
        wr(AR, 9); rd(AR, r); chk("R11 reload ignored run", r, 3);

        // R6 slot order: slots 0,1 pass, slot 2 masked
        wr(AC, 32'h3);
        h = int'(pwm_out);
        begin
            int h2;
            cnt_hi(8, h2);
            h += h2;
        end
        chk("R6 first slots high", h, 9);
        @(negedge clk); chk("R6 slot2 masked", 32'(pwm_out), 0);
        rd(AS, r); chk("R12 rhythm running", 32'(r[2]), 0);
        // R11 ignored while rhythm runs
        wr(AR, 7); rd(AR, r); chk("R11 reload ignored rhythm", r, 3);

        // R6 random patterns
        for (int it = 0; it < 5; it++) begin
            pat = (it == 0) ? 20'h80001 : 20'($urandom);
            wr(AP, 32'(pat));
            repeat (2) @(negedge clk);
            cnt_hi(80, h);
            chk($sformatf("R6 pattern %05h", pat), h, exp_rhy(pat, 4, 0));
        end

        // R9 pending after pass
        repeat (100) @(negedge clk);
        rd(AS, r); chk("R9 pending set", 32'(r[0]), 1);
        chk("R9 irq unmasked", 32'(irq), 1);
        wr(AC, 32'hB); @(negedge clk);
        chk("R9 irq masked", 32'(irq), 0);
        // R10 clear behaviour with rhythm disabled
        wr(AC, 32'h1); @(negedge clk);
        rd(AS, r); chk("R12 rhythm idle", 32'(r[2]), 1);
        chk("R9 irq after unmask", 32'(irq), 1);
        wr(AI, 0); rd(AS, r); chk("R10 write 0 no effect", 32'(r[0]), 1);
        wr(AI, 1); rd(AS, r); chk("R10 clear", 32'(r[0]), 0);
        chk("R10 irq cleared", 32'(irq), 0);

        // R7 pattern ignored when rhythm off
        wr(AP, 0); repeat (3) @(negedge clk);
        cnt_hi(40, h); chk("R7 pattern ignored", h, 40);

        // R8 polarity
        wr(AC, 32'h5); repeat (2) @(negedge clk);
        cnt_hi(40, h); chk("R8 invert no rhythm", h, 0);
        wr(AC, 32'h7); repeat (3) @(negedge clk);
        cnt_hi(80, h); chk("R8 invert masked slots", h, exp_rhy(20'h0, 4, 1));
        pat = 20'($urandom);
        wr(AP, 32'(pat)); repeat (2) @(negedge clk);
        cnt_hi(80, h); chk("R8 invert pattern", h, exp_rhy(pat, 4, 1));

        // R5 inactive level with invert
        stop_wait(32'h4);
        cnt_hi(20, h); chk("R5 R8 inverted idle level", h, 20);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule